// File: doc/BRIEF.md
# Serial Controller Interrupt Identifier

This block takes the interrupt conditions of a 16550-style serial port and turns them into one interrupt request line and one identification byte. The serializer, the receive and transmit FIFOs and the modem pins are outside it. They reach it as plain inputs:
- a receive error pulse;
- the receive FIFO occupancy;
- a character-timeout level;
- a transmit-holding-empty level;
- a modem-change pulse.

A four-bit enable word decides which conditions may raise a request. When several conditions are present, the highest-priority enabled one is encoded into the identification byte. Host read and write strobes clear the conditions the block latches itself.

The receive-data condition compares the FIFO occupancy against a trigger level chosen by a two-bit selector. When the FIFOs are off, any stored byte is enough. The request output is qualified by an output-enable bit, which corresponds to bit 3 of the modem control register.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, with no condition present, the identification byte reads 0x01 (0xC1 with FIFOs on) and the request is low. Bit 0 of the byte is 0 exactly when some enabled condition is pending.
- R2: Enable bits are bit0 receive data and timeout, bit1 transmit holding empty, bit2 receive line status, bit3 modem status. A condition whose enable bit is clear is not reported, but latched conditions stay latched and appear once they are enabled.
- R3: Bits 3:0 of the identification byte are 0x6 for line status, 0x4 for receive data, 0xC for character timeout, 0x2 for transmit empty and 0x0 for modem status.
- R4: Priority from highest to lowest: line status, receive data, character timeout, transmit empty, modem status.
- R5: Bits 7:6 read 11 when the FIFOs are enabled and 00 otherwise. Bits 5:4 read 0.
- R6: The request output is high only when a condition is pending and the output-enable input is 1.
- R7: With FIFOs on, receive data is reported when occupancy reaches the trigger level: selector 00, 01, 10, 11 gives 1, 4, 8, 14 bytes. With FIFOs off, one byte is enough.
- R8: A transmit-empty condition is latched in two cases: when the holding register becomes empty, or when bit1 is enabled while the register is empty. Reading the identification byte while it shows code 0x2 clears it. A read that shows another code leaves it set.
- R9: A write to the holding register clears the transmit-empty condition, unless a new set event occurs in that same cycle.
- R10: A receive error pulse latches the line status condition until the line status register is read. An error pulse in the same cycle as the read keeps it set.
- R11: A modem-change pulse latches the modem condition until the modem status register is read. A change in the same cycle as the read keeps it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| int_en | input | 4 | Interrupt enable word |
| fifo_on | input | 1 | FIFOs enabled |
| trig_sel | input | 2 | Receive trigger level selector |
| rx_level | input | LW | Receive FIFO occupancy |
| rx_timeout | input | 1 | Character timeout level |
| rx_err | input | 1 | Receive line error pulse |
| thr_empty | input | 1 | Transmit holding register empty |
| modem_chg | input | 1 | Modem status change pulse |
| rd_ident | input | 1 | Read strobe of the identification byte |
| rd_line | input | 1 | Read strobe of the line status register |
| rd_modem | input | 1 | Read strobe of the modem status register |
| wr_hold | input | 1 | Write strobe of the holding register |
| out_en | input | 1 | Request output enable |
| ident | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request |

## Verification
The bench stacks every source at once and then removes them one at a time. A priority mistake shows up there as the wrong code while a lower source is still pending. It reads the identification byte while line status hides a pending transmit-empty condition. A design that clears on any read would then lose the transmit interrupt. Each trigger level is driven one byte below and then exactly at its threshold, which exposes off-by-one comparisons. Error pulses that coincide with the clearing read show whether a clear-first design drops an event.

// File: rtl/uart_irq_ident.sv
module uart_irq_ident #(
  parameter int FIFO_DEPTH = 16,
  localparam int LW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    int_en,
  input  logic          fifo_on,
  input  logic [1:0]    trig_sel,
  input  logic [LW-1:0] rx_level,
  input  logic          rx_timeout,
  input  logic          rx_err,
  input  logic          thr_empty,
  input  logic          modem_chg,
  input  logic          rd_ident,
  input  logic          rd_line,
  input  logic          rd_modem,
  input  logic          wr_hold,
  input  logic          out_en,
  output logic [7:0]    ident,
  output logic          irq
);

  localparam logic [3:0] ID_LINE  = 4'h6;
  localparam logic [3:0] ID_RXD   = 4'h4;
  localparam logic [3:0] ID_TOUT  = 4'hC;
  localparam logic [3:0] ID_THRE  = 4'h2;
  localparam logic [3:0] ID_MODEM = 4'h0;
  localparam logic [3:0] ID_NONE  = 4'h1;

  logic line_q, modem_q, thre_q, empty_q, en1_q;
  logic [LW-1:0] thresh;
  logic rx_hit, line_act, rx_act, to_act, thre_act, modem_act;
  logic thre_set, thre_clr;
  logic [3:0] id;

  always_comb begin
    if (!fifo_on) thresh = LW'(1);
    else begin
      case (trig_sel)
        2'b00:   thresh = LW'(1);
        2'b01:   thresh = LW'(4);
        2'b10:   thresh = LW'(8);
        default: thresh = LW'(14);
      endcase
    end
  end

  assign rx_hit    = rx_level >= thresh;
  assign line_act  = line_q  & int_en[2];
  assign rx_act    = rx_hit  & int_en[0];
  assign to_act    = rx_timeout & int_en[0];
  assign thre_act  = thre_q  & int_en[1];
  assign modem_act = modem_q & int_en[3];

  always_comb begin
    if      (line_act)  id = ID_LINE;
    else if (rx_act)    id = ID_RXD;
    else if (to_act)    id = ID_TOUT;
    else if (thre_act)  id = ID_THRE;
    else if (modem_act) id = ID_MODEM;
    else                id = ID_NONE;
  end

  assign ident = {{2{fifo_on}}, 2'b00, id};
  assign irq   = out_en & ~id[0];

  assign thre_set = (thr_empty & ~empty_q) | (thr_empty & int_en[1] & ~en1_q);
  assign thre_clr = wr_hold | (rd_ident & (id == ID_THRE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q  <= 1'b0;
      modem_q <= 1'b0;
      thre_q  <= 1'b0;
      empty_q <= 1'b1;
      en1_q   <= 1'b0;
    end else begin
      empty_q <= thr_empty;
      en1_q   <= int_en[1];
      if (rx_err)       line_q <= 1'b1;
      else if (rd_line) line_q <= 1'b0;
      if (modem_chg)     modem_q <= 1'b1;
      else if (rd_modem) modem_q <= 1'b0;
      if (thre_set)      thre_q <= 1'b1;
      else if (thre_clr) thre_q <= 1'b0;
    end
  end

  p_pend_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !ident[0]);
  p_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> !irq);
  p_line_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (line_q && int_en[2]) |-> (ident[3:0] == 4'h6));
  p_idle_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ident[0] |-> (ident[3:1] == 3'b000));
  p_line_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (line_q && !rd_line) |=> line_q);
  p_modem_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_modem && !modem_chg) |=> !modem_q);
  p_thre_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hold && !thre_set) |=> !thre_q);

endmodule

// File: tb/tb_uart_irq_ident.sv
module tb_uart_irq_ident;
  localparam int LW = 5;
  logic clk = 0, rst_n = 0;
  logic [3:0] int_en = 0;
  logic fifo_on = 0, rx_timeout = 0, rx_err = 0, thr_empty = 1, modem_chg = 0;
  logic [1:0] trig_sel = 0;
  logic [LW-1:0] rx_level = 0;
  logic rd_ident = 0, rd_line = 0, rd_modem = 0, wr_hold = 0, out_en = 0;
  logic [7:0] ident;
  logic irq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uart_irq_ident dut (.clk(clk), .rst_n(rst_n), .int_en(int_en), .fifo_on(fifo_on),
    .trig_sel(trig_sel), .rx_level(rx_level), .rx_timeout(rx_timeout), .rx_err(rx_err),
    .thr_empty(thr_empty), .modem_chg(modem_chg), .rd_ident(rd_ident), .rd_line(rd_line),
    .rd_modem(rd_modem), .wr_hold(wr_hold), .out_en(out_en), .ident(ident), .irq(irq));

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 idle ident", ident, 8'h01);
    chk("R1 idle irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_trigger();
    int_en = 4'b0001; fifo_on = 1;
    trig_sel = 2'b01; rx_level = 3; #1 chk("R7 below 4", ident, 8'hC1);
    rx_level = 4; #1 chk("R7 at 4", ident, 8'hC4);
    trig_sel = 2'b10; rx_level = 7; #1 chk("R7 below 8", ident, 8'hC1);
    rx_level = 8; #1 chk("R7 at 8", ident, 8'hC4);
    trig_sel = 2'b11; rx_level = 13; #1 chk("R7 below 14", ident, 8'hC1);
    rx_level = 14; #1 chk("R7 at 14 R5", ident, 8'hC4);
    trig_sel = 2'b00; rx_level = 1; #1 chk("R7 at 1", ident, 8'hC4);
    fifo_on = 0; trig_sel = 2'b11; #1 chk("R7 no fifo one byte R5", ident, 8'h04);
    rx_level = 0; #1 chk("R7 empty", ident, 8'h01);
    fifo_on = 1; trig_sel = 2'b10; rx_level = 2; rx_timeout = 1;
    #1 chk("R3 timeout code", ident, 8'hCC);
    rx_timeout = 0; rx_level = 0; fifo_on = 0; int_en = 0;
    tick();
  endtask

  task automatic t_enable();
    rx_err = 1; tick(); rx_err = 0;
    chk("R2 masked line", ident, 8'h01);
    int_en = 4'b0100; #1 chk("R2 latched then enabled", ident, 8'h06);
    rd_line = 1; tick(); rd_line = 0;
    chk("R10 cleared by line read", ident, 8'h01);
  endtask

  task automatic t_priority();
    int_en = 4'b0000; rx_err = 1; modem_chg = 1; tick();
    rx_err = 0; modem_chg = 0; rx_level = 1;
    int_en = 4'b1111; tick();
    chk("R4 line first", ident, 8'h06);
    rd_line = 1; tick(); rd_line = 0;
    chk("R4 rx next", ident, 8'h04);
    rx_level = 0; #1 chk("R4 thre next", ident, 8'h02);
    rd_ident = 1; tick(); rd_ident = 0;
    chk("R8 thre cleared by ident read", ident, 8'h00);
    rd_modem = 1; tick(); rd_modem = 0;
    chk("R11 modem cleared", ident, 8'h01);
    int_en = 0; tick();
  endtask

  task automatic t_thre_hidden();
    rx_err = 1; tick(); rx_err = 0;
    int_en = 4'b0110; tick();
    chk("R8 line hides thre", ident, 8'h06);
    rd_ident = 1; tick(); rd_ident = 0;
    rd_line = 1; tick(); rd_line = 0;
    chk("R8 thre survives other read", ident, 8'h02);
    wr_hold = 1; thr_empty = 0; tick(); wr_hold = 0;
    chk("R9 write clears thre", ident, 8'h01);
    thr_empty = 1; tick();
    chk("R8 empty edge sets", ident, 8'h02);
    rd_ident = 1; tick(); rd_ident = 0;
    int_en = 0; tick();
  endtask

  task automatic t_gate_race();
    int_en = 4'b1100; rx_err = 1; tick(); rx_err = 0;
    out_en = 0; #1 chk("R6 gated off", {7'b0, irq}, 8'h00);
    out_en = 1; #1 chk("R6 gated on", {7'b0, irq}, 8'h01);
    rx_err = 1; rd_line = 1; tick(); rx_err = 0; rd_line = 0;
    chk("R10 set wins over read", ident, 8'h06);
    rd_line = 1; tick(); rd_line = 0;
    modem_chg = 1; tick(); modem_chg = 0;
    modem_chg = 1; rd_modem = 1; tick(); modem_chg = 0; rd_modem = 0;
    chk("R11 change wins over read", ident, 8'h00);
    rd_modem = 1; tick(); rd_modem = 0;
    chk("R6 idle no irq", {7'b0, irq}, 8'h00);
    chk("R1 idle again", ident, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; tick();
    t_reset();
    t_trigger();
    t_enable();
    t_priority();
    t_thre_hidden();
    t_gate_race();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule